// File: doc/BRIEF.md
# Shared 64-bit Timer with Per-Core Comparators

This block keeps one 64-bit up-counter that every core of a small cluster (one to four cores) shares. Each core owns a private bank holding a 64-bit comparator, a 32-bit auto-increment step, a sticky event flag and one interrupt line. A core reaches its bank through a 32-bit register bus. A core-select input steers each access to the bank of the requesting core. The run enable and the prescaler are global. Comparator enable, interrupt enable and auto-increment enable belong to the selected core.

When the timer runs, the counter steps once every prescaler+1 clock cycles. A core whose comparator is enabled raises its event flag as soon as the counter reaches or passes its comparator. If auto-increment is on, the comparator then moves forward by the step value, which gives periodic events without software help. Software should change the counter only while the timer is stopped. To read a consistent 64-bit value it reads the high word, then the low word, then the high word again, and retries if the high word changed.

Top module: `gcount_cmp_top`

## Requirements
- R1: After reset, every register of every bank reads zero and all interrupt lines are low.
- R2: While the run bit (control bit 0) is set, the counter increments by one on every (P+1)-th clock edge after the edge that set it, where P is the prescaler. While the run bit is clear, the counter holds its value.
- R3: Word offset 0x00 holds counter bits 31:0 and offset 0x04 holds bits 63:32. Both are writable, and the carry from the low word into the high word wraps the full 64 bits to zero.
- R4: The control register at 0x08 holds run at bit 0, comparator enable at bit 1, interrupt enable at bit 2, auto-increment enable at bit 3 and the prescaler at bits 15:8. Run and prescaler are shared, so a write through any core changes them for all cores. Bits 1 to 3 are stored separately for each core, and only the selected core's copy changes.
- R5: With its comparator enabled, a core's event flag (bit 0 at 0x0C) is set on the edge after the counter first holds a value greater than or equal to the comparator. With the comparator disabled, the flag is never set.
- R6: The event flag is sticky. Writing 1 to bit 0 at 0x0C clears it. If an event occurs in the same cycle as the clear, the flag stays set.
- R7: A core's interrupt output is high exactly while its event flag and its interrupt enable are both set.
- R8: With auto-increment enabled, every event cycle adds the core's 32-bit step (offset 0x18) to its 64-bit comparator.
- R9: The comparator low word (0x10), comparator high word (0x14) and step (0x18) are written and read back per core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | SEL_W | Core issuing the access; selects the banked registers |
| bus_wen | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Byte offset bits 4:2 (word index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register of the selected core (combinational) |
| irq_o | output | NCORE | Interrupt line for each core |

## Verification
A write-1 clear of a core's event flag can land in the same cycle as a new comparison event. The bench provokes this by leaving the counter past a comparator that does not auto-increment and then clearing, so the event condition is still true during the clear cycle. The flag must read 1 afterwards. It drops only once the comparator is disabled and a second clear is written. A global control write can also coincide with banked state held by other cores. The bench writes control through several cores and checks that each core sees the shared prescaler next to its own untouched enable bits.

// File: rtl/gcount_pkg.sv
package gcount_pkg;
   // word index taken from byte offset bits 4:2
   typedef enum logic [2:0] {
      RG_CNT_LO = 3'd0,
      RG_CNT_HI = 3'd1,
      RG_CTRL   = 3'd2,
      RG_STAT   = 3'd3,
      RG_CMP_LO = 3'd4,
      RG_CMP_HI = 3'd5,
      RG_STEP   = 3'd6,
      RG_NONE   = 3'd7
   } reg_idx_e;

   localparam int CB_RUN     = 0;
   localparam int CB_CMP     = 1;
   localparam int CB_IRQ     = 2;
   localparam int CB_AUTO    = 3;
   localparam int CB_PRE_LSB = 8;
   localparam int CB_PRE_MAX = 8;
endpackage

// File: rtl/gcount_prescale.sv
module gcount_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [PRE_W-1:0] pre_i,
   output logic             tick_o
);
   logic [PRE_W-1:0] div_q;

   assign tick_o = run_i && (div_q >= pre_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (!run_i)  div_q <= '0;
      else if (tick_o)  div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   // R2
   tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> run_i);
   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && pre_i != '0 && run_i) |=> (!tick_o || pre_i == '0));
endmodule

// File: rtl/gcount_counter.sv
module gcount_counter #(
   parameter int DW = 32,
   localparam int CW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          wr_lo_i,
   input  logic          wr_hi_i,
   input  logic [DW-1:0] wdata_i,
   output logic [CW-1:0] cnt_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) cnt_q[DW-1:0]  <= wdata_i;
         if (wr_hi_i) cnt_q[CW-1:DW] <= wdata_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
   // R3
   wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_lo_i, wr_hi_i}) <= 1);
endmodule

// File: rtl/gcount_core.sv
module gcount_core
   import gcount_pkg::*;
#(
   parameter int DW = 32,
   localparam int CW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_i,
   input  logic          wen_i,
   input  reg_idx_e      idx_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rd_o,
   output logic          irq_o
);
   logic          cmp_en_q, irq_en_q, auto_q, flag_q;
   logic [CW-1:0] cmp_q;
   logic [DW-1:0] step_q;
   logic          hit, clr_req, cmp_wr;

   assign hit     = cmp_en_q && (cnt_i >= cmp_q);
   assign clr_req = wen_i && (idx_i == RG_STAT) && wdata_i[0];
   assign cmp_wr  = wen_i && ((idx_i == RG_CMP_LO) || (idx_i == RG_CMP_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_en_q <= 1'b0;
         irq_en_q <= 1'b0;
         auto_q   <= 1'b0;
      end else if (wen_i && idx_i == RG_CTRL) begin
         cmp_en_q <= wdata_i[CB_CMP];
         irq_en_q <= wdata_i[CB_IRQ];
         auto_q   <= wdata_i[CB_AUTO];
      end
   end

   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (clr_req)  flag_q <= 1'b0;
   end

   // software writes outrank the auto-increment reload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_wr) begin
         if (idx_i == RG_CMP_LO) cmp_q[DW-1:0]  <= wdata_i;
         else                    cmp_q[CW-1:DW] <= wdata_i;
      end else if (hit && auto_q) begin
         cmp_q <= cmp_q + CW'(step_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           step_q <= '0;
      else if (wen_i && idx_i == RG_STEP)   step_q <= wdata_i;
   end

   always_comb begin
      rd_o = '0;
      unique case (idx_i)
         RG_CTRL: begin
            rd_o[CB_CMP]  = cmp_en_q;
            rd_o[CB_IRQ]  = irq_en_q;
            rd_o[CB_AUTO] = auto_q;
         end
         RG_STAT:   rd_o[0] = flag_q;
         RG_CMP_LO: rd_o = cmp_q[DW-1:0];
         RG_CMP_HI: rd_o = cmp_q[CW-1:DW];
         RG_STEP:   rd_o = step_q;
         default:   rd_o = '0;
      endcase
   end

   assign irq_o = flag_q && irq_en_q;

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_req) |=> flag_q);
   // R5
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cmp_en_q));
   // R8
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !cmp_wr) |=> $stable(cmp_q));
   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !hit) |=> !irq_o);
endmodule

// File: rtl/gcount_cmp_top.sv
module gcount_cmp_top
   import gcount_pkg::*;
#(
   parameter int NCORE = 4,
   parameter int PRE_W = 8,
   localparam int DW    = 32,
   localparam int CW    = 2 * DW,
   localparam int SEL_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] bus_sel,
   input  logic             bus_wen,
   input  logic [4:2]       bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic [NCORE-1:0] irq_o
);
   if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
      $error("gcount_cmp_top: NCORE must lie in 1..4");
   end
   if (PRE_W < 1 || PRE_W > CB_PRE_MAX) begin : g_bad_pre
      $error("gcount_cmp_top: PRE_W must lie in 1..8");
   end

   reg_idx_e         idx;
   logic             run_q;
   logic [PRE_W-1:0] pre_q;
   logic             tick;
   logic [CW-1:0]    cnt;
   logic [DW-1:0]    core_rd [NCORE];
   logic [DW-1:0]    bank_rd;
   logic [DW-1:0]    glob_rd;

   assign idx = reg_idx_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pre_q <= '0;
      end else if (bus_wen && idx == RG_CTRL) begin
         run_q <= bus_wdata[CB_RUN];
         pre_q <= bus_wdata[CB_PRE_LSB +: PRE_W];
      end
   end

   gcount_prescale #(.PRE_W(PRE_W)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_q),
      .pre_i  (pre_q),
      .tick_o (tick)
   );

   gcount_counter #(.DW(DW)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .wr_lo_i (bus_wen && idx == RG_CNT_LO),
      .wr_hi_i (bus_wen && idx == RG_CNT_HI),
      .wdata_i (bus_wdata),
      .cnt_o   (cnt)
   );

   for (genvar c = 0; c < NCORE; c++) begin : g_core
      gcount_core #(.DW(DW)) i_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt_i   (cnt),
         .wen_i   (bus_wen && bus_sel == SEL_W'(c)),
         .idx_i   (idx),
         .wdata_i (bus_wdata),
         .rd_o    (core_rd[c]),
         .irq_o   (irq_o[c])
      );
   end

   always_comb begin
      bank_rd = '0;
      for (int c = 0; c < NCORE; c++) begin
         if (bus_sel == SEL_W'(c)) bank_rd = core_rd[c];
      end
   end

   always_comb begin
      glob_rd = '0;
      glob_rd[CB_RUN] = run_q;
      glob_rd[CB_PRE_LSB +: PRE_W] = pre_q;
   end

   always_comb begin
      unique case (idx)
         RG_CNT_LO: bus_rdata = cnt[DW-1:0];
         RG_CNT_HI: bus_rdata = cnt[CW-1:DW];
         RG_CTRL:   bus_rdata = glob_rd | bank_rd;
         default:   bus_rdata = bank_rd;
      endcase
   end

   // R4
   glob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wen && idx == RG_CTRL) |=> ($stable(run_q) && $stable(pre_q)));
endmodule

// File: tb/test_gcount_cmp_top.sv
module test_gcount_cmp_top;
   localparam int NCORE = 4;
   localparam int A_CLO = 0, A_CHI = 1, A_CTL = 2, A_STA = 3,
                  A_MLO = 4, A_MHI = 5, A_STP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = '0;
   logic        bus_wen = 1'b0;
   logic [4:2]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCORE-1:0] irq_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gcount_cmp_top #(.NCORE(NCORE), .PRE_W(8)) i_gcount_cmp_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wen(bus_wen),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int c, int a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 2'(c); bus_addr = 3'(a); bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(int c, int a, output logic [31:0] d);
      bus_sel = 2'(c); bus_addr = 3'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic zero_cnt();
      wr(0, A_CLO, 32'h0);
      wr(0, A_CHI, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      int pres[4] = '{0, 1, 2, 5};
      #1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, every register of every bank
      for (int c = 0; c < NCORE; c++)
         for (int a = 0; a < 7; a++) begin
            rd(c, a, v);
            chk("R1", 64'(v), 64'h0);
         end
      chk("R1 irq", 64'(irq_o), 64'h0);

      // R2 prescaler sweep
      foreach (pres[i]) begin
         zero_cnt();
         wr(0, A_CTL, 32'(pres[i] << 8) | 32'h1);
         repeat (20) @(negedge clk);
         rd(0, A_CLO, v);
         chk("R2 rate", 64'(v), 64'(20 / (pres[i] + 1)));
         wr(0, A_CTL, 32'h0);
         rd(0, A_CLO, v);
         repeat (5) @(negedge clk);
         rd(0, A_CLO, v2);
         chk("R2 hold", 64'(v2), 64'(v));
      end

      // R3 64-bit carry and wrap
      wr(0, A_CLO, 32'hFFFF_FFFE);
      wr(0, A_CHI, 32'hFFFF_FFFF);
      rd(0, A_CHI, v);
      chk("R3 hi write", 64'(v), 64'hFFFF_FFFF);
      wr(0, A_CTL, 32'h1);
      repeat (3) @(negedge clk);
      rd(0, A_CLO, v);
      chk("R3 wrap lo", 64'(v), 64'h1);
      rd(0, A_CHI, v);
      chk("R3 wrap hi", 64'(v), 64'h0);
      wr(0, A_CTL, 32'h0);

      // R5/R7 per-core event, interrupt masked on odd cores
      for (int c = 0; c < NCORE; c++) begin
         int t = 4 + c;
         bit ie = (c % 2 == 0);
         zero_cnt();
         wr(c, A_MLO, 32'(t));
         wr(c, A_MHI, 32'h0);
         wr(c, A_CTL, 32'h3 | (ie ? 32'h4 : 32'h0));
         repeat (t) @(negedge clk);
         rd(c, A_STA, v);
         chk("R5 before", 64'(v), 64'h0);
         chk("R7 before", 64'(irq_o), 64'h0);
         @(negedge clk);
         rd(c, A_STA, v);
         chk("R5 set", 64'(v), 64'h1);
         chk("R7 irq", 64'(irq_o), ie ? 64'(1 << c) : 64'h0);
         wr(c, A_CTL, 32'h0);
         wr(c, A_STA, 32'h1);
         rd(c, A_STA, v);
         chk("R6 clear", 64'(v), 64'h0);
      end

      // R5 comparator disabled: no event
      zero_cnt();
      wr(1, A_MLO, 32'h2);
      wr(1, A_CTL, 32'h5);
      repeat (8) @(negedge clk);
      rd(1, A_STA, v);
      chk("R5 disabled", 64'(v), 64'h0);
      wr(1, A_CTL, 32'h0);

      // R6 clear colliding with a live event
      zero_cnt();
      wr(0, A_MLO, 32'h2);
      wr(0, A_CTL, 32'h7);
      repeat (6) @(negedge clk);
      wr(0, A_STA, 32'h1);
      rd(0, A_STA, v);
      chk("R6 collide", 64'(v), 64'h1);
      chk("R7 collide", 64'(irq_o), 64'h1);
      wr(0, A_CTL, 32'h5);
      wr(0, A_STA, 32'h1);
      rd(0, A_STA, v);
      chk("R6 cleared", 64'(v), 64'h0);
      chk("R7 cleared", 64'(irq_o), 64'h0);
      wr(0, A_CTL, 32'h0);

      // R4 global versus banked fields
      wr(1, A_CTL, 32'h0000_070A);
      wr(2, A_CTL, 32'h0000_0304);
      rd(1, A_CTL, v);
      chk("R4 core1", 64'(v), 64'h030A);
      rd(2, A_CTL, v);
      chk("R4 core2", 64'(v), 64'h0304);
      rd(3, A_CTL, v);
      chk("R4 core3", 64'(v), 64'h0300);
      for (int c = 0; c < NCORE; c++) wr(c, A_CTL, 32'h0);

      // R8 auto-increment, model built from the rule
      begin
         int cs[2] = '{5, 2};
         int is[2] = '{3, 7};
         foreach (cs[k]) begin
            longint m;
            zero_cnt();
            wr(3, A_MLO, 32'(cs[k]));
            wr(3, A_MHI, 32'h0);
            wr(3, A_STP, 32'(is[k]));
            wr(3, A_CTL, 32'hB);
            repeat (15) @(negedge clk);
            m = cs[k];
            for (int n = 1; n <= 15; n++) if (longint'(n - 1) >= m) m += is[k];
            rd(3, A_MLO, v);
            chk("R8 reload", 64'(v), 64'(m));
            rd(3, A_STA, v);
            chk("R8 flag", 64'(v), 64'h1);
            wr(3, A_CTL, 32'h0);
            wr(3, A_STA, 32'h1);
         end
      end

      // R9 banked readback
      wr(2, A_MHI, 32'hA5A5_0001);
      wr(2, A_STP, 32'h0000_1234);
      rd(2, A_MHI, v);
      chk("R9 cmp hi", 64'(v), 64'hA5A5_0001);
      rd(2, A_STP, v);
      chk("R9 step", 64'(v), 64'h1234);
      rd(0, A_MHI, v);
      chk("R9 other bank", 64'(v), 64'h0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule